// File: doc/BRIEF.md
# General-Purpose I/O Controller with Level-Match Interrupts

This block is a bank of general-purpose pins controlled through a small word-addressed register bus. Each pin either stays a plain GPIO or is handed over to an alternate-function source. The alternate-function output, output-enable and input signals pass straight through on ports of their own. A GPIO pin can be an input or an output. Software reads the pin levels and writes the values driven on output pins.

Every pin has an interrupt status bit that is set in any cycle where the pin's value equals a per-pin programmed level. The status bit then holds until software clears it. The pending bits are split between two interrupt lines by a per-pin routing mask: an ordinary maskable line and a non-maskable line.

Pad inputs are synchronised before use. The pad multiplexer outputs, the read data and both interrupt lines are registered.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, the function, direction, output-data, level and non-maskable-routing registers are all zero. Every pin is a GPIO input and `pin_oe` is all zeros.
- R2: Register word index (`bus_addr`): 0 function select, 1 direction, 2 data, 3 interrupt level, 4 interrupt status, 5 non-maskable routing. Index 6 and 7 read as zero. `bus_rdata` is loaded at the clock edge where `bus_rd` is high.
- R3: A function bit of 1 routes `alt_out` and `alt_oe` of that pin to `pin_out` and `pin_oe`. `alt_in` always mirrors `pin_in`.
- R4: For a GPIO pin (function bit 0), `pin_oe` is the direction bit, where 1 means output. `pin_out` is the data register bit. Pad outputs appear one cycle after the register changes.
- R5: Reading the data register returns the written data bit for GPIO output pins. For all other pins it returns `pin_in` after a two-flop synchroniser.
- R6: A status bit is set in every cycle where the pin value equals its level bit. With reset values and `pin_in` low, every status bit therefore becomes set right after reset.
- R7: Status bits are sticky. Writing 0 to a status bit clears it and writing 1 has no effect. A match in the same cycle as a clear leaves the bit set.
- R8: `nmi` is the OR of status bits whose routing bit is 1. `irq` is the OR of status bits whose routing bit is 0. Both are registered one cycle behind the status bits.
- R9: The pin value compared for a GPIO output pin is the driven data bit, not the pad input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Registered read data |
| pin_in | input | NPINS | Pad input levels |
| pin_out | output | NPINS | Pad output levels |
| pin_oe | output | NPINS | Pad output enables |
| alt_out | input | NPINS | Alternate-function output values |
| alt_oe | input | NPINS | Alternate-function output enables |
| alt_in | output | NPINS | Pad inputs handed to alternate functions |
| irq | output | 1 | Maskable interrupt |
| nmi | output | 1 | Non-maskable interrupt |

## Verification
The bench drives a short pad pulse, removes it, and then reads status. A design that tracked the condition instead of latching it would read zero.

It writes all ones to status and expects nothing to clear. It also clears a bit whose match is still live and expects the bit to remain set. A design with inverted clear polarity, or one where the clear wins, fails one of these.

Routing is tested by pending one pin on each line and watching that each appears on only its own output. An output pin driven high against a low pad must still match a high level. A design that compared the raw pad would miss that match.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_FUNC  = 3'd0,
    REG_DIR   = 3'd1,
    REG_DATA  = 3'd2,
    REG_LEVEL = 3'd3,
    REG_STAT  = 3'd4,
    REG_NMIEN = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [REG_AW-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      pin_val,
  input  logic [W-1:0]      status,
  output logic [W-1:0]      func_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      dout_q,
  output logic [W-1:0]      level_q,
  output logic [W-1:0]      nmien_q,
  output logic              stat_wr,
  output logic [W-1:0]      rdata
);
  logic [W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      func_q  <= '0;
      dir_q   <= '0;
      dout_q  <= '0;
      level_q <= '0;
      nmien_q <= '0;
    end else if (wr) begin
      case (addr)
        REG_FUNC:  func_q  <= wdata;
        REG_DIR:   dir_q   <= wdata;
        REG_DATA:  dout_q  <= wdata;
        REG_LEVEL: level_q <= wdata;
        REG_NMIEN: nmien_q <= wdata;
        default: ;
      endcase
    end
  end

  assign stat_wr = wr && (addr == REG_STAT);

  always_comb begin
    case (addr)
      REG_FUNC:  rd_mux = func_q;
      REG_DIR:   rd_mux = dir_q;
      REG_DATA:  rd_mux = pin_val;
      REG_LEVEL: rd_mux = level_q;
      REG_STAT:  rd_mux = status;
      REG_NMIEN: rd_mux = nmien_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_val,
  input  logic [W-1:0] level,
  input  logic         stat_wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] nmien,
  output logic [W-1:0] status,
  output logic         irq,
  output logic         nmi
);
  logic [W-1:0] hit;
  logic [W-1:0] keep;

  assign hit  = ~(pin_val ^ level);
  assign keep = stat_wr ? (status & wdata) : status;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
      nmi    <= 1'b0;
    end else begin
      status <= keep | hit;
      irq    <= |(status & ~nmien);
      nmi    <= |(status & nmien);
    end
  end
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  input  logic [NPINS-1:0]  alt_out,
  input  logic [NPINS-1:0]  alt_oe,
  output logic [NPINS-1:0]  alt_in,
  output logic              irq,
  output logic              nmi
);
  logic [NPINS-1:0] sync_q;
  logic [NPINS-1:0] func_q, dir_q, dout_q, level_q, nmien_q;
  logic [NPINS-1:0] status, pin_val, gp_drive;
  logic             stat_wr;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(sync_q)
  );

  assign gp_drive = dir_q & ~func_q;
  assign pin_val  = (gp_drive & dout_q) | (~gp_drive & sync_q);

  gpio_regs #(.W(NPINS)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .pin_val(pin_val), .status(status),
    .func_q(func_q), .dir_q(dir_q), .dout_q(dout_q), .level_q(level_q),
    .nmien_q(nmien_q), .stat_wr(stat_wr), .rdata(bus_rdata)
  );

  gpio_irq #(.W(NPINS)) u_irq (
    .clk(clk), .rst(rst), .pin_val(pin_val), .level(level_q),
    .stat_wr(stat_wr), .wdata(bus_wdata), .nmien(nmien_q),
    .status(status), .irq(irq), .nmi(nmi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
      pin_oe  <= '0;
    end else begin
      pin_out <= (func_q & alt_out) | (~func_q & dout_q);
      pin_oe  <= (func_q & alt_oe)  | (~func_q & dir_q);
    end
  end

  assign alt_in = pin_in;
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [NPINS-1:0] func_q,
  input logic [NPINS-1:0] dir_q,
  input logic [NPINS-1:0] level_q,
  input logic [NPINS-1:0] nmien_q,
  input logic [NPINS-1:0] status,
  input logic [NPINS-1:0] pin_val,
  input logic             stat_wr,
  input logic [NPINS-1:0] bus_wdata,
  input logic [NPINS-1:0] pin_oe,
  input logic             irq,
  input logic             nmi
);
  logic [NPINS-1:0] eq_vec;
  assign eq_vec = ~(pin_val ^ level_q);

  // R4: a GPIO pin's enable follows its direction bit one cycle later
  assert_oe_gate_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pin_oe & ~$past(func_q)) == ($past(dir_q) & ~$past(func_q))));

  // R6: a match always leaves its status bit set
  assert_match_sets_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((status & $past(eq_vec)) == $past(eq_vec)));

  // R7: without a status write, set bits stay set
  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(stat_wr)) |-> ((status & $past(status)) == $past(status)));

  // R7: on a status write, bits written 0 hold only the fresh match
  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(stat_wr)) |->
      ((status & ~$past(bus_wdata)) == ($past(eq_vec) & ~$past(bus_wdata))));

  // R8: routing of pending bits to the two lines
  assert_nmi_route_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (nmi == |($past(status) & $past(nmien_q))));

  assert_irq_route_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq == |($past(status) & ~$past(nmien_q))));
endmodule

bind gpio_ctrl gpio_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst(rst), .func_q(func_q), .dir_q(dir_q), .level_q(level_q),
  .nmien_q(nmien_q), .status(status), .pin_val(pin_val), .stat_wr(stat_wr),
  .bus_wdata(bus_wdata), .pin_oe(pin_oe), .irq(irq), .nmi(nmi)
);

// File: tb/tb_gpio_ctrl.sv
module tb_gpio_ctrl;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]   bus_addr = '0;
  logic [N-1:0] bus_wdata = '0, bus_rdata;
  logic [N-1:0] pin_in = '0, pin_out, pin_oe;
  logic [N-1:0] alt_out = '0, alt_oe = '0, alt_in;
  logic         irq, nmi;

  int checks = 0;
  int errors = 0;

  gpio_ctrl #(.NPINS(N)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .alt_out(alt_out), .alt_oe(alt_oe),
    .alt_in(alt_in), .irq(irq), .nmi(nmi)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [N-1:0] v;
    rd(3'd0, v); check("R1 func", v, '0);
    rd(3'd1, v); check("R1 dir", v, '0);
    rd(3'd3, v); check("R1 level", v, '0);
    rd(3'd5, v); check("R1 nmien", v, '0);
    rd(3'd2, v); check("R1 data", v, '0);
    check("R1 pin_oe", pin_oe, '0);
    rd(3'd4, v); check("R6 status after reset", v, '1);
  endtask

  task automatic t_map();
    logic [N-1:0] v;
    wr(3'd3, 32'h1357_9BDF); rd(3'd3, v); check("R2 level readback", v, 32'h1357_9BDF);
    wr(3'd5, 32'h0F0F_0000); rd(3'd5, v); check("R2 nmien readback", v, 32'h0F0F_0000);
    rd(3'd6, v); check("R2 unmapped index", v, '0);
    wr(3'd5, '0); wr(3'd3, '0);
  endtask

  task automatic t_gpio_out();
    logic [N-1:0] v;
    wr(3'd1, 32'h0000_FFFF);
    wr(3'd2, 32'hA5A5_1234);
    pin_in = 32'h5A5A_0000;
    cyc(4);
    check("R4 pin_oe", pin_oe, 32'h0000_FFFF);
    check("R4 pin_out", pin_out, 32'hA5A5_1234);
    rd(3'd2, v); check("R5 data read mix", v, 32'h5A5A_1234);
  endtask

  task automatic t_alt();
    wr(3'd0, 32'h0000_00F0);
    alt_out = 32'hFFFF_FFFF;
    alt_oe  = 32'h0000_00A0;
    cyc(2);
    check("R3 pin_out alt", pin_out, 32'hA5A5_12F4);
    check("R3 pin_oe alt", pin_oe, 32'h0000_FF0F | 32'h0000_00A0);
    check("R3 alt_in", alt_in, pin_in);
    wr(3'd0, '0); wr(3'd1, '0); wr(3'd2, '0);
    alt_out = '0; alt_oe = '0; pin_in = '0;
  endtask

  task automatic t_sticky();
    logic [N-1:0] v;
    wr(3'd3, '1);
    cyc(3);
    wr(3'd4, '0);
    rd(3'd4, v); check("R7 cleared", v, '0);
    pin_in = 32'h8; cyc(4); pin_in = '0; cyc(4);
    rd(3'd4, v); check("R7 sticky after pulse", v, 32'h8);
    wr(3'd4, '1);
    rd(3'd4, v); check("R7 write one no effect", v, 32'h8);
    wr(3'd4, ~32'h8);
    rd(3'd4, v); check("R7 write zero clears", v, '0);
  endtask

  task automatic t_clear_race();
    logic [N-1:0] v;
    wr(3'd3, ~32'h20);
    cyc(2);
    wr(3'd4, '0);
    rd(3'd4, v); check("R7 match wins over clear", v, 32'h20);
    wr(3'd3, '1); wr(3'd4, '0);
  endtask

  task automatic t_route();
    wr(3'd5, 32'h8);
    pin_in = 32'h8; cyc(4); pin_in = '0; cyc(3);
    check("R8 nmi set", {31'd0, nmi}, 32'd1);
    check("R8 irq quiet", {31'd0, irq}, 32'd0);
    pin_in = 32'h10; cyc(4); pin_in = '0; cyc(3);
    check("R8 irq set", {31'd0, irq}, 32'd1);
    wr(3'd4, '0); cyc(3);
    check("R8 lines clear", {30'd0, irq, nmi}, 32'd0);
    wr(3'd5, '0);
  endtask

  task automatic t_out_compare();
    logic [N-1:0] v;
    wr(3'd1, 32'h1);
    wr(3'd2, 32'h0);
    cyc(2); wr(3'd4, '0);
    rd(3'd4, v); check("R9 no match when driven low", v, '0);
    wr(3'd2, 32'h1);
    cyc(2);
    rd(3'd4, v); check("R9 driven value matches", v, 32'h1);
  endtask

  initial begin
    fork
      begin
        cyc(3);
        rst = 1'b0;
        t_reset();
        t_map();
        t_gpio_out();
        t_alt();
        t_sticky();
        t_clear_race();
        t_route();
        t_out_compare();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule